// File: doc/BRIEF.md
# Lane Instruction-Block Sequencer

This unit sits at the head of one lane of a vector-thread engine. It takes fetch commands that name an instruction-block address and, for each command, checks that address once against a small tagged block cache. On a miss it asks an outside fill port for the block and waits until every word has arrived. It then steps the lane's in-order execution cluster through the block, one instruction at a time, and tags each instruction with the global index of the virtual processor (VP) it runs for.

A vector command runs the block for every VP that lives on this lane, in ascending VP order. A thread command runs the block for a single VP. VPs have no program counter of their own. A block keeps a VP's thread alive only by holding a fetch instruction, which can be predicated on a per-VP condition flag. Follow-on fetches that are still waiting are served lowest VP first. A new command is not taken until all of this follow-on work has drained.

Top module: `vt_lane_sequencer`

## Requirements
- R1: After reset, `cmd_ready_o` is 1 and `instr_valid_o` and `fill_req_o` are 0.
- R2: A command whose block is not cached raises `fill_req_o` with `fill_addr_o` equal to the block address. Both hold steady until the last of BLK_LEN (8) fill beats is taken. No instruction issues while the fill is outstanding.
- R3: A command to a block that is already cached raises no fill request.
- R4: A vector command issues the block once for each of the VPS_PER_LANE local VPs, in ascending local order. The tag on each instruction is local*NUM_LANES+LANE_ID.
- R5: A thread command issues the block only for the VP it names. If that VP belongs to another lane (index modulo NUM_LANES differs from LANE_ID), nothing is issued.
- R6: A block ends at its first word with bit 31 (end marker) set. If no word in its 8 words has the marker, it ends after the 8th word.
- R7: A word with bit 30 (fetch) set makes that VP run the block at the address in bits 15:0 once its current block ends. If the block has no fetch that takes effect, the VP's thread stops.
- R8: A fetch word with bit 29 (predicated) set takes effect only when `vp_pred_i[local VP]` is 1 at the time it issues.
- R9: When several VPs have follow-on fetches waiting, they run in ascending VP order.
- R10: `cmd_ready_o` drops in the cycle after a command is taken. It does not return until every instruction launched by that command, including follow-on fetches, has been issued.
- R11: The cache is direct-mapped on block-address bits 1:0 over 4 slots. Loading a block with a different address into a slot evicts the old block, so returning to the old block needs a new fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Fetch command present |
| cmd_ready_o | output | 1 | Sequencer idle, command may be taken |
| cmd_thread_i | input | 1 | 1: single-VP command, 0: all-VP command |
| cmd_vp_i | input | GVP_W (4) | Global VP index for a single-VP command |
| cmd_addr_i | input | ADDR_W (16) | Block address |
| vp_pred_i | input | VPS_PER_LANE (4) | Per-local-VP condition flag for predicated fetches |
| fill_req_o | output | 1 | Block fill request |
| fill_addr_o | output | ADDR_W (16) | Address of the block to fill |
| fill_valid_i | input | 1 | Fill beat present |
| fill_data_i | input | INSTR_W (32) | Fill beat word, in block order |
| instr_valid_o | output | 1 | Instruction issued this cycle |
| instr_o | output | INSTR_W (32) | Issued instruction word |
| instr_vp_o | output | GVP_W (4) | Global VP index the instruction runs for |

## Verification
A block is run as an all-VP command and again as a repeat of that command. Comparing the two runs tells a real cache hit apart from a refill, and shows that the VP ordering and tags come from the command kind rather than from the cache state. Single-VP commands to a resident VP and to a VP of another lane separate correct residency filtering from a block that is simply broadcast. A block with a predicated fetch, run under a split predicate vector, tells per-VP predicate use and lowest-first service of waiting fetches apart from an unconditional or reordered chain. An 8-word block with no end marker and a slot conflict between two addresses cover the length limit and eviction.

// File: rtl/vt_lane_pkg.sv
package vt_lane_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_FILL,
    S_NEXT,
    S_RD,
    S_EX
  } seq_state_e;
endpackage

// File: rtl/vt_lane_pick.sv
module vt_lane_pick #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/vt_lane_tags.sv
module vt_lane_tags #(
  parameter int ADDR_W = 16,
  parameter int SLOTS  = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int TAG_W  = ADDR_W - SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr
);
  logic [TAG_W-1:0] tag_q [SLOTS];
  logic [SLOTS-1:0] val_q;

  wire [SLOT_W-1:0] look_slot = look_addr[SLOT_W-1:0];
  wire [SLOT_W-1:0] wr_slot   = wr_addr[SLOT_W-1:0];

  assign hit = val_q[look_slot] && (tag_q[look_slot] == look_addr[ADDR_W-1:SLOT_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
      for (int i = 0; i < SLOTS; i++) tag_q[i] <= '0;
    end else if (wr_en) begin
      val_q[wr_slot] <= 1'b1;
      tag_q[wr_slot] <= wr_addr[ADDR_W-1:SLOT_W];
    end
  end
endmodule

// File: rtl/vt_lane_blkmem.sv
module vt_lane_blkmem #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vt_lane_sequencer.sv
module vt_lane_sequencer #(
  parameter int NUM_LANES    = 4,
  parameter int LANE_ID      = 0,
  parameter int VPS_PER_LANE = 4,
  parameter int SLOTS        = 4,
  parameter int BLK_LEN      = 8,
  parameter int ADDR_W       = 16,
  parameter int INSTR_W      = 32,
  localparam int LANE_W = $clog2(NUM_LANES),
  localparam int VPL_W  = $clog2(VPS_PER_LANE),
  localparam int GVP_W  = LANE_W + VPL_W,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int PC_W   = $clog2(BLK_LEN),
  localparam int MEM_AW = SLOT_W + PC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic               cmd_thread_i,
  input  logic [GVP_W-1:0]   cmd_vp_i,
  input  logic [ADDR_W-1:0]  cmd_addr_i,
  input  logic [VPS_PER_LANE-1:0] vp_pred_i,
  output logic               fill_req_o,
  output logic [ADDR_W-1:0]  fill_addr_o,
  input  logic               fill_valid_i,
  input  logic [INSTR_W-1:0] fill_data_i,
  output logic               instr_valid_o,
  output logic [INSTR_W-1:0] instr_o,
  output logic [GVP_W-1:0]   instr_vp_o
);
  import vt_lane_pkg::*;

  localparam int END_B  = INSTR_W - 1;
  localparam int FTCH_B = INSTR_W - 2;
  localparam int PRED_B = INSTR_W - 3;

  seq_state_e               state_q;
  logic [ADDR_W-1:0]        job_addr_q;
  logic [VPS_PER_LANE-1:0]  run_mask_q;
  logic [VPL_W-1:0]         cur_vp_q;
  logic [PC_W-1:0]          pc_q;
  logic [PC_W-1:0]          beat_q;
  logic                     fseen_q;
  logic [ADDR_W-1:0]        faddr_q;
  logic [VPS_PER_LANE-1:0]  pend_v_q;
  logic [ADDR_W-1:0]        pend_a_q [VPS_PER_LANE];

  // command decode
  wire              cmd_take = cmd_valid_i && (state_q == S_IDLE);
  wire              resident = (cmd_vp_i[LANE_W-1:0] == LANE_W'(LANE_ID));
  wire [VPL_W-1:0]  cmd_loc  = cmd_vp_i[GVP_W-1:LANE_W];

  assign cmd_ready_o = (state_q == S_IDLE);

  // cache
  logic tag_hit;
  wire  fill_last = (state_q == S_FILL) && fill_valid_i && (beat_q == PC_W'(BLK_LEN - 1));

  vt_lane_tags #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) tags_i (
    .clk(clk), .rst(rst),
    .look_addr(job_addr_q), .hit(tag_hit),
    .wr_en(fill_last), .wr_addr(job_addr_q)
  );

  logic [INSTR_W-1:0] rd_word;
  wire  [SLOT_W-1:0]  job_slot = job_addr_q[SLOT_W-1:0];

  vt_lane_blkmem #(.WIDTH(INSTR_W), .DEPTH(SLOTS * BLK_LEN)) mem_i (
    .clk(clk),
    .we(state_q == S_FILL && fill_valid_i),
    .waddr({job_slot, beat_q}),
    .wdata(fill_data_i),
    .raddr({job_slot, pc_q}),
    .rdata(rd_word)
  );

  // VP selection
  logic             run_any, pend_any;
  logic [VPL_W-1:0] run_idx, pend_idx;

  vt_lane_pick #(.N(VPS_PER_LANE)) pick_run_i  (.req(run_mask_q), .any(run_any),  .idx(run_idx));
  vt_lane_pick #(.N(VPS_PER_LANE)) pick_pend_i (.req(pend_v_q),   .any(pend_any), .idx(pend_idx));

  // execute-step decode
  wire fetch_now = rd_word[FTCH_B] && (!rd_word[PRED_B] || vp_pred_i[cur_vp_q]);
  wire blk_last  = rd_word[END_B] || (pc_q == PC_W'(BLK_LEN - 1));
  wire              fseen_n = fetch_now ? 1'b1 : fseen_q;
  wire [ADDR_W-1:0] faddr_n = fetch_now ? rd_word[ADDR_W-1:0] : faddr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= S_IDLE;
      job_addr_q    <= '0;
      run_mask_q    <= '0;
      cur_vp_q      <= '0;
      pc_q          <= '0;
      beat_q        <= '0;
      fseen_q       <= 1'b0;
      faddr_q       <= '0;
      pend_v_q      <= '0;
      for (int i = 0; i < VPS_PER_LANE; i++) pend_a_q[i] <= '0;
      fill_req_o    <= 1'b0;
      fill_addr_o   <= '0;
      instr_valid_o <= 1'b0;
      instr_o       <= '0;
      instr_vp_o    <= '0;
    end else begin
      instr_valid_o <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (cmd_take) begin
            job_addr_q <= cmd_addr_i;
            if (!cmd_thread_i) begin
              run_mask_q <= '1;
              state_q    <= S_LOOK;
            end else if (resident) begin
              run_mask_q          <= '0;
              run_mask_q[cmd_loc] <= 1'b1;
              state_q             <= S_LOOK;
            end else begin
              run_mask_q <= '0;
              state_q    <= S_NEXT;
            end
          end
        end
        S_LOOK: begin
          if (tag_hit) begin
            state_q <= S_NEXT;
          end else begin
            fill_req_o  <= 1'b1;
            fill_addr_o <= job_addr_q;
            beat_q      <= '0;
            state_q     <= S_FILL;
          end
        end
        S_FILL: begin
          if (fill_valid_i) begin
            beat_q <= beat_q + PC_W'(1);
            if (fill_last) begin
              fill_req_o <= 1'b0;
              beat_q     <= '0;
              state_q    <= S_LOOK;
            end
          end
        end
        S_NEXT: begin
          if (run_any) begin
            cur_vp_q <= run_idx;
            pc_q     <= '0;
            fseen_q  <= 1'b0;
            state_q  <= S_RD;
          end else if (pend_any) begin
            job_addr_q           <= pend_a_q[pend_idx];
            pend_v_q[pend_idx]   <= 1'b0;
            run_mask_q           <= '0;
            run_mask_q[pend_idx] <= 1'b1;
            state_q              <= S_LOOK;
          end else begin
            state_q <= S_IDLE;
          end
        end
        S_RD: begin
          state_q <= S_EX;
        end
        S_EX: begin
          instr_valid_o <= 1'b1;
          instr_o       <= rd_word;
          instr_vp_o    <= {cur_vp_q, LANE_W'(LANE_ID)};
          if (blk_last) begin
            pend_v_q[cur_vp_q]   <= fseen_n;
            pend_a_q[cur_vp_q]   <= faddr_n;
            run_mask_q[cur_vp_q] <= 1'b0;
            fseen_q              <= 1'b0;
            state_q              <= S_NEXT;
          end else begin
            fseen_q <= fseen_n;
            faddr_q <= faddr_n;
            pc_q    <= pc_q + PC_W'(1);
            state_q <= S_RD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vt_lane_sequencer_chk.sv
module vt_lane_sequencer_chk #(
  parameter int NUM_LANES = 4,
  parameter int LANE_ID   = 0,
  parameter int GVP_W     = 4,
  parameter int ADDR_W    = 16,
  parameter int INSTR_W   = 32,
  localparam int LANE_W = $clog2(NUM_LANES)
) (
  input logic               clk,
  input logic               rst,
  input logic               cmd_valid_i,
  input logic               cmd_ready_o,
  input logic               fill_req_o,
  input logic [ADDR_W-1:0]  fill_addr_o,
  input logic               fill_valid_i,
  input logic               instr_valid_o,
  input logic [INSTR_W-1:0] instr_o,
  input logic [GVP_W-1:0]   instr_vp_o
);
  // R2: request and address held until beats arrive
  p_fill_hold_r2: assert property (@(posedge clk) disable iff (rst)
    fill_req_o && !fill_valid_i |=> fill_req_o && $stable(fill_addr_o));

  // R2: nothing issues while a fill is outstanding
  p_no_issue_in_fill_r2: assert property (@(posedge clk) disable iff (rst)
    fill_req_o |-> !instr_valid_o);

  // R4: every issued instruction carries a VP of this lane
  p_lane_tag_r4: assert property (@(posedge clk) disable iff (rst)
    instr_valid_o |-> instr_vp_o[LANE_W-1:0] == LANE_W'(LANE_ID));

  // R10: taking a command makes the sequencer busy
  p_busy_after_take_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_i && cmd_ready_o |=> !cmd_ready_o);

  // R10: a fill never overlaps an idle sequencer
  p_fill_busy_r10: assert property (@(posedge clk) disable iff (rst)
    fill_req_o |-> !cmd_ready_o);

  // R6: an end-marked word is not followed by another issue next cycle
  p_end_gap_r6: assert property (@(posedge clk) disable iff (rst)
    instr_valid_o && instr_o[INSTR_W-1] |=> !instr_valid_o);
endmodule

bind vt_lane_sequencer vt_lane_sequencer_chk #(
  .NUM_LANES(NUM_LANES), .LANE_ID(LANE_ID), .GVP_W(GVP_W),
  .ADDR_W(ADDR_W), .INSTR_W(INSTR_W)
) chk_i (
  .clk(clk), .rst(rst),
  .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
  .fill_req_o(fill_req_o), .fill_addr_o(fill_addr_o), .fill_valid_i(fill_valid_i),
  .instr_valid_o(instr_valid_o), .instr_o(instr_o), .instr_vp_o(instr_vp_o)
);

// File: tb/vt_lane_sequencer_tb_top.sv
module vt_lane_sequencer_tb_top;
  localparam int NL = 4, LID = 1, VPL = 4, BL = 8, AW = 16, IW = 32, GW = 4;
  localparam logic [15:0] BA = 16'h0010, BB = 16'h0021, BC = 16'h0032,
                          BD = 16'h0043, BE = 16'h0014;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid_i = 1'b0, cmd_ready_o, cmd_thread_i = 1'b0;
  logic [GW-1:0] cmd_vp_i = '0;
  logic [AW-1:0] cmd_addr_i = '0;
  logic [VPL-1:0] vp_pred_i = '0;
  logic fill_req_o, fill_valid_i = 1'b0;
  logic [AW-1:0] fill_addr_o;
  logic [IW-1:0] fill_data_i = '0;
  logic instr_valid_o;
  logic [IW-1:0] instr_o;
  logic [GW-1:0] instr_vp_o;

  always #5 clk = ~clk;

  vt_lane_sequencer #(.NUM_LANES(NL), .LANE_ID(LID), .VPS_PER_LANE(VPL), .SLOTS(4),
    .BLK_LEN(BL), .ADDR_W(AW), .INSTR_W(IW)) dut_i (.*);

  int checks = 0, errors = 0, fill_n = 0;
  logic [AW-1:0] fill_last_a = '0;
  bit done = 0;
  int rec_n = 0, exp_n = 0;
  logic [GW-1:0] rec_vp [256], exp_vp [256];
  logic [IW-1:0] rec_w [256], exp_w [256];

  // block image: {end, fetch, pred, 5'index, 8'hA5, low16}
  function automatic logic [IW-1:0] wd(input logic [15:0] a, input int i);
    logic e = 1'b0, f = 1'b0, p = 1'b0;
    logic [15:0] lo = a;
    case (a)
      BA: e = (i == 2);
      BC: begin if (i == 0) begin f = 1'b1; p = 1'b1; lo = BD; end e = (i == 1); end
      BD: e = (i == 1);
      BE: e = (i == 0);
      default: e = (a != BB);
    endcase
    return {e, f, p, 5'(i), 8'hA5, lo};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic exp_block(input int gvp, input logic [15:0] a);
    for (int i = 0; i < BL; i++) begin
      exp_vp[exp_n] = GW'(gvp);
      exp_w[exp_n]  = wd(a, i);
      exp_n++;
      if (wd(a, i)[IW-1]) break;
    end
  endtask

  // fill responder
  initial begin
    forever begin
      @(negedge clk);
      if (fill_req_o) begin
        fill_n++;
        fill_last_a = fill_addr_o;
        @(negedge clk);
        for (int i = 0; i < BL; i++) begin
          fill_valid_i = 1'b1;
          fill_data_i  = wd(fill_addr_o, i);
          @(negedge clk);
        end
        fill_valid_i = 1'b0;
      end
    end
  end

  // issue monitor
  always @(negedge clk) begin
    if (!rst && instr_valid_o && rec_n < 256) begin
      rec_vp[rec_n] = instr_vp_o;
      rec_w[rec_n]  = instr_o;
      rec_n++;
    end
  end

  task automatic run_cmd(input bit thr, input int vp, input logic [15:0] a, input string req);
    int t = 0;
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_thread_i = thr; cmd_vp_i = GW'(vp); cmd_addr_i = a;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    #1;
    check(cmd_ready_o == 1'b0, {"R10 busy after take ", req}, cmd_ready_o, 0);
    while (!cmd_ready_o && t < 2000) begin
      @(negedge clk); #1; t++;
    end
    check(rec_n == exp_n, {"R10 all issued when ready ", req}, rec_n, exp_n);
  endtask

  task automatic compare(input string req);
    check(rec_n == exp_n, {req, " count"}, rec_n, exp_n);
    for (int i = 0; i < exp_n && i < rec_n; i++) begin
      check(rec_vp[i] == exp_vp[i], {req, " vp"}, rec_vp[i], exp_vp[i]);
      check(rec_w[i] == exp_w[i], {req, " word"}, rec_w[i], exp_w[i]);
    end
  endtask

  task automatic clear();
    rec_n = 0; exp_n = 0;
  endtask

  task automatic t_reset();
    #1;
    check(cmd_ready_o == 1'b1, "R1 ready", cmd_ready_o, 1);
    check(instr_valid_o == 1'b0, "R1 valid", instr_valid_o, 0);
    check(fill_req_o == 1'b0, "R1 fill", fill_req_o, 0);
  endtask

  task automatic t_vec_miss();
    int f0 = fill_n;
    clear();
    for (int k = 0; k < VPL; k++) exp_block(k * NL + LID, BA);
    run_cmd(1'b0, 0, BA, "vec miss");
    check(fill_n == f0 + 1, "R2 one fill", fill_n, f0 + 1);
    check(fill_last_a == BA, "R2 fill addr", fill_last_a, BA);
    compare("R4 R6 vector order");
  endtask

  task automatic t_vec_hit();
    int f0 = fill_n;
    clear();
    for (int k = 0; k < VPL; k++) exp_block(k * NL + LID, BA);
    run_cmd(1'b0, 0, BA, "vec hit");
    check(fill_n == f0, "R3 no fill on hit", fill_n, f0);
    compare("R3 R4 hit rerun");
  endtask

  task automatic t_thread();
    clear();
    exp_block(9, BB);
    run_cmd(1'b1, 9, BB, "thread");
    check(fill_last_a == BB, "R2 fill addr B", fill_last_a, BB);
    compare("R5 R6 single VP full block");
  endtask

  task automatic t_foreign();
    int f0 = fill_n;
    clear();
    run_cmd(1'b1, 6, BA, "foreign");
    check(fill_n == f0, "R5 foreign no fill", fill_n, f0);
    compare("R5 foreign dropped");
  endtask

  task automatic t_chain();
    int f0 = fill_n;
    clear();
    vp_pred_i = 4'b1010;
    for (int k = 0; k < VPL; k++) exp_block(k * NL + LID, BC);
    exp_block(1 * NL + LID, BD);
    exp_block(3 * NL + LID, BD);
    run_cmd(1'b0, 0, BC, "chain");
    check(fill_n == f0 + 2, "R7 fills for C and D", fill_n, f0 + 2);
    compare("R7 R8 R9 predicated chain");
    vp_pred_i = '0;
  endtask

  task automatic t_evict();
    int f0 = fill_n;
    clear();
    exp_block(LID, BE);
    run_cmd(1'b1, LID, BE, "evict E");
    check(fill_n == f0 + 1, "R11 fill E", fill_n, f0 + 1);
    for (int k = 0; k < VPL; k++) exp_block(k * NL + LID, BA);
    run_cmd(1'b0, 0, BA, "evict A");
    check(fill_n == f0 + 2, "R11 refill A", fill_n, f0 + 2);
    check(fill_last_a == BA, "R11 refill addr", fill_last_a, BA);
    compare("R11 after eviction");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_vec_miss();
    t_vec_hit();
    t_thread();
    t_foreign();
    t_chain();
    t_evict();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule